// File: doc/BRIEF.md
# Radix-4 Montgomery Modular Exponentiator

This block raises a base to an exponent modulo an odd modulus, M^E mod N. It never divides by N. Every modular product is a Montgomery product that takes two multiplier bits per step. The block recodes those two bits, plus the bit below them, into a signed digit in {-2,-1,0,+1,+2}. A digit therefore only ever adds a shifted or negated copy of the multiplicand. A quotient digit in {0..3} is then chosen so that the two low bits of the running sum become zero, and the sum is shifted right by two.

The exponent is scanned from its least significant bit upward. The squaring chain S = S·S does not depend on the accumulation P = P·S, so both run in a single two-stage datapath on alternating cycles. The block first converts the base into the Montgomery domain and also produces the domain's image of 1. It does this with one product against the caller-supplied constant R² mod N, where R = 4^D and D = floor(W/2)+1. After the last exponent bit, a final product against 1 converts the result back out of the domain.

The caller drives a one-cycle `start` together with the operands. `busy` then stays high until a one-cycle `done` marks a valid `result`.

Top module: `mx_modexp`

## Requirements
- R1: After reset, `busy`, `done` and `result` are all 0.
- R2: A `start` pulse taken while `busy` is low raises `busy` from the next cycle. `busy` stays high until the cycle in which `done` pulses, and `busy` and `done` are never high together.
- R3: `done` is high for exactly one cycle. `result` changes only in a cycle in which `done` is high, and holds its value until the next completion.
- R4: The inputs must satisfy: N odd and N ≥ 3, base < N, and `rsq` = 4^(2D) mod N with D = floor(W/2)+1. Under those conditions `result` at `done` equals base^E mod N, for every W-bit exponent.
- R5: An exponent of 0 yields `result` = 1.
- R6: A `start` pulse while `busy` is high is ignored. The running operation completes with the result for its own operands, and no extra `done` follows.
- R7: At `done`, `result` is strictly below the modulus latched at start.
- R8: The number of cycles from `start` to `done` is the same for every operand and exponent value at a given W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request; operands sampled with it |
| base | input | W | Base M, below N |
| expo | input | W | Exponent E |
| modulus | input | W | Odd modulus N |
| rsq | input | W | Domain constant 4^(2D) mod N |
| busy | output | 1 | High while an exponentiation runs |
| done | output | 1 | One-cycle completion pulse |
| result | output | W | M^E mod N, valid from `done` |

## Verification
The assertions check the handshake on every cycle: a start taken when idle raises busy, busy falls only together with done, done lasts one cycle, result changes only at done, and a finished result lies below the latched modulus. Only the bench scenarios can show that the result is the correct power for random and corner operands (exponent 0, exponent 1, base 0, all-ones exponent, the smallest and largest moduli). The same holds for a start pulse in mid-run having no effect on the value, and for latency that is independent of the data.

// File: rtl/mx_pkg.sv
package mx_pkg;

  // Signed radix-4 digit after Booth recoding of three multiplier bits
  typedef enum logic [2:0] {DG_ZERO, DG_POS1, DG_POS2, DG_NEG1, DG_NEG2} bdigit_e;

  typedef enum logic [1:0] {PP_IDLE, PP_RUN, PP_DRAIN, PP_FIX} pipe_st_e;

  typedef enum logic [2:0] {XS_IDLE, XS_WCONV, XS_ISTEP, XS_WSTEP, XS_IFIN, XS_WFIN} exp_st_e;

  // {b(2i+1), b(2i), b(2i-1)} -> -2*b(2i+1) + b(2i) + b(2i-1)
  function automatic bdigit_e booth_decode(input logic [2:0] g);
    case (g)
      3'b001, 3'b010: return DG_POS1;
      3'b011:         return DG_POS2;
      3'b100:         return DG_NEG2;
      3'b101, 3'b110: return DG_NEG1;
      default:        return DG_ZERO;
    endcase
  endfunction

  // -N^-1 mod 4 for odd N: 3 when N mod 4 is 1, 1 when N mod 4 is 3
  function automatic logic [1:0] neg_inv4(input logic [1:0] n_lo);
    return n_lo[1] ? 2'd1 : 2'd3;
  endfunction

endpackage

// File: rtl/mx_booth_pp.sv
module mx_booth_pp import mx_pkg::*; #(
  parameter int W  = 16,
  parameter int TW = W + 4
) (
  input  logic [2:0]           grp,
  input  logic [W-1:0]         a,
  output logic signed [TW-1:0] pp
);

  bdigit_e              dig;
  logic signed [TW-1:0] ax;

  always_comb begin
    dig = booth_decode(grp);
    ax  = $signed({{(TW-W){1'b0}}, a});
    case (dig)
      DG_POS1: pp = ax;
      DG_POS2: pp = ax <<< 1;
      DG_NEG1: pp = -ax;
      DG_NEG2: pp = -(ax <<< 1);
      default: pp = '0;
    endcase
  end

endmodule

// File: rtl/mx_mont_reduce.sv
module mx_mont_reduce import mx_pkg::*; #(
  parameter int W  = 16,
  parameter int TW = W + 4
) (
  input  logic signed [TW-1:0] u,
  input  logic [W-1:0]         n,
  output logic signed [TW-1:0] t
);

  logic [1:0]           q;
  logic signed [TW-1:0] nx;
  logic signed [TW-1:0] qn;
  logic signed [TW-1:0] sum;

  always_comb begin
    // quotient digit clears the two low bits of u + q*N
    q  = u[1:0] * neg_inv4(n[1:0]);
    nx = $signed({{(TW-W){1'b0}}, n});
    case (q)
      2'd1:    qn = nx;
      2'd2:    qn = nx <<< 1;
      2'd3:    qn = nx + (nx <<< 1);
      default: qn = '0;
    endcase
    sum = u + qn;
    t   = sum >>> 2;
  end

endmodule

// File: rtl/mx_mont_pipe.sv
module mx_mont_pipe import mx_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [1:0]   ld_act,
  input  logic [W-1:0] ld_a0,
  input  logic [W-1:0] ld_b0,
  input  logic [W-1:0] ld_a1,
  input  logic [W-1:0] ld_b1,
  input  logic [W-1:0] n,
  output logic [W-1:0] res0,
  output logic [W-1:0] res1,
  output logic         fin
);

  localparam int ND = W / 2 + 1;          // radix-4 digits per product
  localparam int BW = 2 * ND;             // zero-extended multiplier width
  localparam int TW = W + 4;              // signed accumulator width
  localparam int CW = $clog2(ND + 1);

  pipe_st_e             st_q, st_d;
  logic                 ph_q, ph_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic signed [TW-1:0] t_q [2];
  logic signed [TW-1:0] t_d [2];
  logic [W-1:0]         a_q [2];
  logic [W-1:0]         a_d [2];
  logic [BW-1:0]        b_q [2];
  logic [BW-1:0]        b_d [2];
  logic [1:0]           pb_q, pb_d;
  logic [1:0]           act_q, act_d;
  logic signed [TW-1:0] u_q, u_d;
  logic                 uc_q, uc_d;
  logic                 uv_q, uv_d;
  logic                 fin_q, fin_d;
  logic signed [TW-1:0] pp [2];
  logic signed [TW-1:0] red_t;
  logic signed [TW-1:0] nn;

  assign nn = $signed({{(TW-W){1'b0}}, n});

  function automatic logic signed [TW-1:0] fold(input logic signed [TW-1:0] v,
                                                 input logic signed [TW-1:0] m);
    if (v < 0)       return v + m;
    else if (v >= m) return v - m;
    return v;
  endfunction

  // stage one: one Booth partial product per lane
  for (genvar k = 0; k < 2; k++) begin : g_lane
    mx_booth_pp #(.W(W), .TW(TW)) u_pp (
      .grp ({b_q[k][1:0], pb_q[k]}),
      .a   (a_q[k]),
      .pp  (pp[k])
    );
  end

  // stage two: quotient digit and divide by four
  mx_mont_reduce #(.W(W), .TW(TW)) u_red (
    .u (u_q),
    .n (n),
    .t (red_t)
  );

  always_comb begin
    st_d  = st_q;
    ph_d  = ph_q;
    cnt_d = cnt_q;
    pb_d  = pb_q;
    act_d = act_q;
    u_d   = u_q;
    uc_d  = uc_q;
    uv_d  = 1'b0;
    fin_d = 1'b0;
    for (int k = 0; k < 2; k++) begin
      t_d[k] = t_q[k];
      a_d[k] = a_q[k];
      b_d[k] = b_q[k];
    end
    if (uv_q) t_d[uc_q] = red_t;
    unique case (st_q)
      PP_IDLE: begin
        if (ld) begin
          st_d   = PP_RUN;
          ph_d   = 1'b0;
          cnt_d  = '0;
          act_d  = ld_act;
          a_d[0] = ld_a0;
          a_d[1] = ld_a1;
          b_d[0] = BW'(ld_b0);
          b_d[1] = BW'(ld_b1);
          pb_d   = '0;
          t_d[0] = '0;
          t_d[1] = '0;
        end
      end
      PP_RUN: begin
        if (act_q[ph_q]) begin
          u_d  = t_q[ph_q] + pp[ph_q];
          uc_d = ph_q;
          uv_d = 1'b1;
        end
        b_d[ph_q]  = b_q[ph_q] >> 2;
        pb_d[ph_q] = b_q[ph_q][1];
        ph_d       = ~ph_q;
        if (ph_q) begin
          if (cnt_q == CW'(ND - 1)) st_d = PP_DRAIN;
          else                      cnt_d = cnt_q + 1'b1;
        end
      end
      PP_DRAIN: st_d = PP_FIX;
      PP_FIX: begin
        t_d[0] = fold(t_q[0], nn);
        t_d[1] = fold(t_q[1], nn);
        fin_d  = 1'b1;
        st_d   = PP_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PP_IDLE;
      ph_q   <= 1'b0;
      cnt_q  <= '0;
      pb_q   <= '0;
      act_q  <= '0;
      u_q    <= '0;
      uc_q   <= 1'b0;
      uv_q   <= 1'b0;
      fin_q  <= 1'b0;
      for (int k = 0; k < 2; k++) begin
        t_q[k] <= '0;
        a_q[k] <= '0;
        b_q[k] <= '0;
      end
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      pb_q   <= pb_d;
      act_q  <= act_d;
      u_q    <= u_d;
      uc_q   <= uc_d;
      uv_q   <= uv_d;
      fin_q  <= fin_d;
      for (int k = 0; k < 2; k++) begin
        t_q[k] <= t_d[k];
        a_q[k] <= a_d[k];
        b_q[k] <= b_d[k];
      end
    end
  end

  assign res0 = t_q[0][W-1:0];
  assign res1 = t_q[1][W-1:0];
  assign fin  = fin_q;

endmodule

// File: rtl/mx_modexp.sv
module mx_modexp import mx_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] base,
  input  logic [W-1:0] expo,
  input  logic [W-1:0] modulus,
  input  logic [W-1:0] rsq,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);

  localparam int EC = $clog2(W + 1);

  logic [1:0]    rsync_q;
  logic          rst_s_n;
  exp_st_e       st_q, st_d;
  logic [W-1:0]  n_q, n_d;
  logic [W-1:0]  e_q, e_d;
  logic [W-1:0]  s_q, s_d;
  logic [W-1:0]  p_q, p_d;
  logic [W-1:0]  res_q, res_d;
  logic [EC-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          n_en, e_en, s_en, p_en, res_en, cnt_en;
  logic          ld;
  logic [1:0]    ld_act;
  logic [W-1:0]  la0, lb0, la1, lb1;
  logic [W-1:0]  res0, res1;
  logic          fin;

  // reset asserts at once, leaves in step with the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  mx_mont_pipe #(.W(W)) u_pipe (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .ld     (ld),
    .ld_act (ld_act),
    .ld_a0  (la0),
    .ld_b0  (lb0),
    .ld_a1  (la1),
    .ld_b1  (lb1),
    .n      (n_q),
    .res0   (res0),
    .res1   (res1),
    .fin    (fin)
  );

  always_comb begin
    st_d   = st_q;
    n_d    = modulus;
    e_d    = expo;
    s_d    = res0;
    p_d    = res1;
    res_d  = res1;
    cnt_d  = '0;
    done_d = 1'b0;
    n_en   = 1'b0;
    e_en   = 1'b0;
    s_en   = 1'b0;
    p_en   = 1'b0;
    res_en = 1'b0;
    cnt_en = 1'b0;
    ld     = 1'b0;
    ld_act = 2'b00;
    la0    = '0;
    lb0    = '0;
    la1    = '0;
    lb1    = '0;
    unique case (st_q)
      XS_IDLE: begin
        if (start) begin
          // lane 0: base into domain, lane 1: image of one
          ld     = 1'b1;
          ld_act = 2'b11;
          la0    = base;
          lb0    = rsq;
          la1    = W'(1);
          lb1    = rsq;
          n_en   = 1'b1;
          e_en   = 1'b1;
          cnt_en = 1'b1;
          st_d   = XS_WCONV;
        end
      end
      XS_WCONV: begin
        if (fin) begin
          s_en = 1'b1;
          p_en = 1'b1;
          st_d = XS_ISTEP;
        end
      end
      XS_ISTEP: begin
        // lane 0 squares, lane 1 multiplies only for a set exponent bit
        ld     = 1'b1;
        ld_act = {e_q[0], 1'b1};
        la0    = s_q;
        lb0    = s_q;
        la1    = p_q;
        lb1    = s_q;
        st_d   = XS_WSTEP;
      end
      XS_WSTEP: begin
        if (fin) begin
          s_en   = 1'b1;
          p_en   = e_q[0];
          e_d    = e_q >> 1;
          e_en   = 1'b1;
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
          st_d   = (cnt_q == EC'(W - 1)) ? XS_IFIN : XS_ISTEP;
        end
      end
      XS_IFIN: begin
        ld     = 1'b1;
        ld_act = 2'b10;
        la1    = p_q;
        lb1    = W'(1);
        st_d   = XS_WFIN;
      end
      XS_WFIN: begin
        if (fin) begin
          res_en = 1'b1;
          done_d = 1'b1;
          st_d   = XS_IDLE;
        end
      end
      default: st_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q   <= XS_IDLE;
      n_q    <= '0;
      e_q    <= '0;
      s_q    <= '0;
      p_q    <= '0;
      res_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (n_en)   n_q   <= n_d;
      if (e_en)   e_q   <= e_d;
      if (s_en)   s_q   <= s_d;
      if (p_en)   p_q   <= p_d;
      if (res_en) res_q <= res_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy   = (st_q != XS_IDLE);
  assign done   = done_q;
  assign result = res_q;

endmodule

// File: rtl/mx_modexp_chk.sv
module mx_modexp_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] result,
  input logic [W-1:0] n_lat
);

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  // R2
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R2
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  // R7
  result_below_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result < n_lat));

endmodule

bind mx_modexp mx_modexp_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_s_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .result (result),
  .n_lat  (n_q)
);

// File: tb/mx_modexp_test.sv
module mx_modexp_test;

  localparam int W     = 16;
  localparam int ND    = W / 2 + 1;
  localparam int LIMIT = 5000;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [W-1:0] base, expo, modulus, rsq;
  logic         busy, done;
  logic [W-1:0] result;

  int n_chk  = 0;
  int n_fail = 0;
  int lat0   = -1;

  mx_modexp #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .expo(expo),
    .modulus(modulus), .rsq(rsq), .busy(busy), .done(done), .result(result)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint ref_pow(longint m, longint e, longint n);
    longint r = 1 % n;
    longint s = m % n;
    for (int i = 0; i < W; i++) begin
      if (((e >> i) & 1) != 0) r = (r * s) % n;
      s = (s * s) % n;
    end
    return r;
  endfunction

  function automatic longint calc_r2(longint n);
    longint v = 1 % n;
    for (int i = 0; i < 4 * ND; i++) v = (v * 2) % n;
    return v;
  endfunction

  task automatic drive(input longint m, input longint e, input longint n);
    base    = m[W-1:0];
    expo    = e[W-1:0];
    modulus = n[W-1:0];
    rsq     = calc_r2(n);
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
  endtask

  task automatic run_op(input longint m, input longint e, input longint n, input string req);
    int     cyc = 1;
    longint exp_v = ref_pow(m, e, n);
    @(negedge clk);
    drive(m, e, n);
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    while (!done && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
    end
    check(done == 1'b1, "R2 completion", done, 1);
    check(result == exp_v, req, result, exp_v);
    check(busy == 1'b0, "R2 busy low at done", busy, 0);
    check(result < n, "R7 result below modulus", result, n);
    if (lat0 < 0) lat0 = cyc;
    check(cyc == lat0, "R8 constant latency", cyc, lat0);
    @(negedge clk);
    check(done == 1'b0, "R3 done one cycle", done, 0);
    check(result == exp_v, "R3 result holds", result, exp_v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; start = 1'b0; base = '0; expo = '0; modulus = '0; rsq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0,   "R1 busy", busy, 0);
    check(done == 1'b0,   "R1 done", done, 0);
    check(result == '0,   "R1 result", result, 0);

    // directed corners
    run_op(5, 3, 7, "R4 small");
    run_op(1234, 0, 40001, "R5 zero exponent");
    run_op(0, 0, 3, "R5 zero exponent zero base");
    run_op(4321, 1, 65535, "R4 exponent one");
    run_op(0, 9, 101, "R4 zero base");
    run_op(40000, 2, 40001, "R4 base N-1 squared");
    run_op(2, 16'hFFFF, 3, "R4 smallest modulus");
    run_op(65534, 16'hFFFF, 65535, "R4 all-ones exponent");
    run_op(3, 16'h8000, 65521, "R4 top exponent bit only");

    // R6: second start while busy is ignored
    begin
      int     cyc = 1;
      longint exp_v = ref_pow(777, 12345, 30011);
      @(negedge clk);
      drive(777, 12345, 30011);
      repeat (40) @(negedge clk);
      drive(5, 3, 7);
      while (!done && cyc < LIMIT) begin
        @(negedge clk);
        cyc++;
      end
      check(result == exp_v, "R6 result of first operands", result, exp_v);
      for (int i = 0; i < 600; i++) begin
        @(negedge clk);
        if (done || busy) begin
          check(1'b0, "R6 no extra done", 1, 0);
          break;
        end
      end
      check(result == exp_v, "R6 result unchanged", result, exp_v);
    end

    // R4 random operands
    for (int i = 0; i < 40; i++) begin
      longint n = (($urandom % 65533) + 3) | 1;
      longint m = $urandom % n;
      longint e = $urandom & 16'hFFFF;
      run_op(m, e, n, "R4 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule